// File: doc/BRIEF.md
# Banked Cartridge Address Mapper with RAM Overlay

This block sits on a 13-bit CPU address bus and serves a 4 KB cartridge window (address bit 12 set) from 16 KB of banked ROM and 2 KB of RAM. It has no control register of its own. It watches every CPU write, and when a write lands on the I/O port address 0x0280 it keeps a copy of the byte. The I/O device still receives that write through its own wiring.

The copied byte drives three things:
- which of four 4 KB ROM banks is visible;
- whether the upper 2 KB of the window shows ROM or RAM, and whether that RAM can be written;
- a keyboard column counter that runs from 0 to 9.

Read data comes out one cycle after the address is presented. The ROM is a computed mask pattern, so every byte is known without a preload.

Top module: `cart_bank_mapper`

## Requirements
- R1: A write with `addr_i` equal to 13'h0280 loads `wdata_i` into the 8-bit port copy. Writes to any other address leave the port copy unchanged.
- R2: Port bits [1:0] select the ROM bank b. ROM byte address a = {b, addr_i[11:0]}. The byte held at a is a[7:0] XOR (a[13:8] << 2), truncated to 8 bits.
- R3: Reads from 0x1000–0x17FF always return ROM of the selected bank.
- R4: Reads from 0x1800–0x1FFF return ROM of the selected bank when port bit 4 is 1. When port bit 4 is 0, they return the RAM byte at index addr_i[10:0].
- R5: A write in 0x1800–0x1FFF stores into RAM only when port bits [5:4] are 2'b10. In every other mode the write leaves RAM unchanged.
- R6: After reset, the port copy is 8'hFF (bank 3, upper half shows ROM) and `col_o` is 0. Reset does not clear RAM contents.
- R7: A port write with bit 5 set clears the column counter.
- R8: A port write with bit 6 set advances the column counter modulo 10, so 9 wraps to 0. With bits 5 and 6 both set, the clear applies first and the counter ends at 1.
- R9: Writes to the ROM-mapped part of the window do not change what ROM reads return.
- R10: `rdata_o` reflects the address of the previous cycle. Reads with bit 12 clear return 8'h00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 13 | CPU address |
| wdata_i | input | 8 | CPU write data |
| we_i | input | 1 | CPU write strobe |
| rdata_o | output | 8 | Registered read data |
| col_o | output | 4 | Keyboard column index |

## Verification
A single port write can clear and advance the column counter and also switch the bank and the overlay mode, all on the same edge. The bench provokes this with writes of 0x60-type values combined with bank and mode bits. It judges the counter value on `col_o` right after the edge, and it judges the new mapping by a ROM or RAM read on the next cycle. It also interleaves RAM writes and read-back with mode changes, to show that write gating follows the port copy and not the previous mode.

// File: rtl/cart_bank_pkg.sv
package cart_bank_pkg;
  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_ROM  = 2'd1,
    SRC_RAM  = 2'd2
  } rd_src_e;

  localparam int unsigned PORT_RAM_RD_BIT = 4;  // 1: upper half from ROM
  localparam int unsigned PORT_RAM_WE_BIT = 5;  // doubles as column clear
  localparam int unsigned PORT_COL_INC_BIT = 6;
endpackage

// File: rtl/cart_port_snoop.sv
module cart_port_snoop #(
  parameter int unsigned ADDR_W    = 13,
  parameter int unsigned DATA_W    = 8,
  parameter logic [12:0] PORT_ADDR = 13'h0280,
  parameter int unsigned COLS      = 10,
  localparam int unsigned COL_W    = $clog2(COLS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              we_i,
  output logic [DATA_W-1:0] port_o,
  output logic [COL_W-1:0]  col_o
);
  import cart_bank_pkg::*;

  localparam logic [COL_W-1:0] COL_LAST = COL_W'(COLS - 1);

  logic              port_we;
  logic [COL_W-1:0]  col_clr, col_d;

  assign port_we = we_i && (addr_i == ADDR_W'(PORT_ADDR));

  always_comb begin
    col_clr = wdata_i[PORT_RAM_WE_BIT] ? '0 : col_o;
    col_d   = col_clr;
    if (wdata_i[PORT_COL_INC_BIT])
      col_d = (col_clr == COL_LAST) ? '0 : col_clr + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      port_o <= '1;
      col_o  <= '0;
    end else if (port_we) begin
      port_o <= wdata_i;
      col_o  <= col_d;
    end
  end

  assert_port_hold_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !port_we |=> $stable(port_o));
  assert_port_load_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    port_we |=> port_o == $past(wdata_i));
  assert_col_range_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    col_o <= COL_LAST);
  assert_col_both_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    port_we && wdata_i[PORT_RAM_WE_BIT] && wdata_i[PORT_COL_INC_BIT] |=> col_o == COL_W'(1));
  assert_col_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    port_we && wdata_i[PORT_RAM_WE_BIT] && !wdata_i[PORT_COL_INC_BIT] |=> col_o == '0);
endmodule

// File: rtl/cart_map_decode.sv
module cart_map_decode #(
  parameter int unsigned ADDR_W     = 13,
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned BANK_W     = 2,
  parameter int unsigned BANK_OFS_W = 12,
  localparam int unsigned ROM_AW    = BANK_W + BANK_OFS_W,
  localparam int unsigned RAM_AW    = BANK_OFS_W - 1
) (
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic                 we_i,
  input  logic [DATA_W-1:0]    port_i,
  output cart_bank_pkg::rd_src_e src_o,
  output logic [ROM_AW-1:0]    rom_addr_o,
  output logic [RAM_AW-1:0]    ram_addr_o,
  output logic                 ram_we_o
);
  import cart_bank_pkg::*;

  logic in_win, upper, ram_rd, ram_wr_mode;

  assign in_win      = addr_i[ADDR_W-1];
  assign upper       = addr_i[BANK_OFS_W-1];
  assign ram_rd      = !port_i[PORT_RAM_RD_BIT];
  assign ram_wr_mode = port_i[PORT_RAM_WE_BIT] && !port_i[PORT_RAM_RD_BIT];

  assign rom_addr_o = {port_i[BANK_W-1:0], addr_i[BANK_OFS_W-1:0]};
  assign ram_addr_o = addr_i[RAM_AW-1:0];
  assign ram_we_o   = we_i && in_win && upper && ram_wr_mode;

  always_comb begin
    if (!in_win)              src_o = SRC_NONE;
    else if (upper && ram_rd) src_o = SRC_RAM;
    else                      src_o = SRC_ROM;
  end
endmodule

// File: rtl/cart_ram.sv
module cart_ram #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned AW     = 11,
  localparam int unsigned DEPTH = 1 << AW
) (
  input  logic              clk_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              we_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem[addr_i] <= wdata_i;
    rdata_o <= mem[addr_i];
  end
endmodule

// File: rtl/cart_bank_mapper.sv
module cart_bank_mapper #(
  parameter int unsigned ADDR_W     = 13,
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned BANK_W     = 2,
  parameter int unsigned BANK_OFS_W = 12,
  parameter logic [12:0] PORT_ADDR  = 13'h0280,
  parameter int unsigned COLS       = 10,
  localparam int unsigned COL_W     = $clog2(COLS),
  localparam int unsigned ROM_AW    = BANK_W + BANK_OFS_W,
  localparam int unsigned RAM_AW    = BANK_OFS_W - 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              we_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [COL_W-1:0]  col_o
);
  import cart_bank_pkg::*;

  logic [DATA_W-1:0] port_q;
  rd_src_e           src_d, src_q;
  logic [ROM_AW-1:0] rom_addr;
  logic [RAM_AW-1:0] ram_addr;
  logic              ram_we;
  logic [DATA_W-1:0] rom_byte, rom_q, ram_q;

  cart_port_snoop #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PORT_ADDR(PORT_ADDR), .COLS(COLS)
  ) u_snoop (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .wdata_i(wdata_i),
    .we_i(we_i), .port_o(port_q), .col_o(col_o)
  );

  cart_map_decode #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BANK_W(BANK_W), .BANK_OFS_W(BANK_OFS_W)
  ) u_decode (
    .addr_i(addr_i), .we_i(we_i), .port_i(port_q), .src_o(src_d),
    .rom_addr_o(rom_addr), .ram_addr_o(ram_addr), .ram_we_o(ram_we)
  );

  cart_ram #(.DATA_W(DATA_W), .AW(RAM_AW)) u_ram (
    .clk_i(clk_i), .addr_i(ram_addr), .wdata_i(wdata_i), .we_i(ram_we),
    .rdata_o(ram_q)
  );

  // mask ROM pattern: low byte xor (page bits shifted up by two)
  assign rom_byte = rom_addr[DATA_W-1:0] ^ DATA_W'(rom_addr >> 8 << 2);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_q <= SRC_NONE;
      rom_q <= '0;
    end else begin
      src_q <= src_d;
      rom_q <= rom_byte;
    end
  end

  always_comb begin
    unique case (src_q)
      SRC_ROM: rdata_o = rom_q;
      SRC_RAM: rdata_o = ram_q;
      default: rdata_o = '0;
    endcase
  end

  assert_ram_we_gate_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ram_we |-> port_q[PORT_RAM_WE_BIT +: 1] == 1'b1 && !port_q[PORT_RAM_RD_BIT]
              && addr_i[ADDR_W-1] && addr_i[BANK_OFS_W-1]);
  assert_lower_rom_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_i[ADDR_W-1] && !addr_i[BANK_OFS_W-1] |=> src_q == SRC_ROM);
  assert_outside_zero_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !addr_i[ADDR_W-1] |=> rdata_o == '0);
  assert_overlay_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_i[ADDR_W-1] && addr_i[BANK_OFS_W-1] && !port_q[PORT_RAM_RD_BIT] |=> src_q == SRC_RAM);
endmodule

// File: tb/cart_bank_mapper_test.sv
module cart_bank_mapper_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [12:0] addr_i = '0;
  logic [7:0]  wdata_i = '0;
  logic        we_i = 1'b0;
  logic [7:0]  rdata_o;
  logic [3:0]  col_o;

  int compared = 0;
  int mismatched = 0;
  bit done = 0;

  logic [7:0] port_m;
  int         col_m;
  logic [7:0] ram_m [2048];
  bit         ram_v [2048];

  cart_bank_mapper uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .wdata_i(wdata_i),
    .we_i(we_i), .rdata_o(rdata_o), .col_o(col_o)
  );

  always #10 clk_i = ~clk_i;

  function automatic logic [7:0] rom_exp(int bank, int ofs);
    int a = bank * 4096 + ofs;
    return 8'(((a % 256) ^ ((a / 256) * 4)) % 256);
  endfunction

  task automatic cmp(input int act, input int exp, input string req);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [12:0] a, input logic [7:0] d);
    addr_i = a; wdata_i = d; we_i = 1'b1;
    @(negedge clk_i);
    we_i = 1'b0;
    if (a == 13'h0280) begin
      port_m = d;
      if (d[5]) col_m = 0;
      if (d[6]) col_m = (col_m + 1) % 10;
    end else if (a[12] && a[11] && port_m[5:4] == 2'b10) begin
      ram_m[a[10:0]] = d; ram_v[a[10:0]] = 1;
    end
  endtask

  task automatic rd(input logic [12:0] a, input logic [7:0] exp, input string req);
    addr_i = a; we_i = 1'b0;
    @(negedge clk_i);
    cmp(rdata_o, exp, req);
  endtask

  function automatic logic [7:0] model_rd(logic [12:0] a);
    if (!a[12]) return 8'h00;
    if (!a[11] || port_m[4]) return rom_exp(port_m[1:0], a[11:0]);
    return ram_m[a[10:0]];
  endfunction

  initial begin
    repeat (300000) @(posedge clk_i);
    if (!done) begin
      mismatched++; compared++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    port_m = 8'hFF; col_m = 0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R6 reset state: bank 3, upper half ROM, column 0
    cmp(col_o, 0, "R6 col");
    rd(13'h1800, rom_exp(3, 12'h800), "R6 upper rom bank3");
    rd(13'h1234, rom_exp(3, 12'h234), "R6 lower rom bank3");
    // R10 outside window and latency
    rd(13'h0100, 8'h00, "R10 outside");
    addr_i = 13'h1005;
    @(negedge clk_i);
    addr_i = 13'h0000;
    cmp(rdata_o, rom_exp(3, 5), "R10 one-cycle latency");
    @(negedge clk_i);

    // R2 R3 R4 sweep every bank with ROM overlay (bit4=1)
    for (int b = 0; b < 4; b++) begin
      wr(13'h0280, 8'h10 | 8'(b));
      for (int o = 0; o < 4096; o += 37)
        rd(13'h1000 + 13'(o), rom_exp(b, o), o < 2048 ? "R3 lower rom" : "R2 R4 upper rom");
    end

    // R1 non-port write near port address leaves mapping alone
    wr(13'h0281, 8'h02);
    rd(13'h1800, rom_exp(3, 12'h800), "R1 no capture");
    wr(13'h1280, 8'h01);
    rd(13'h1800, rom_exp(3, 12'h800), "R1 window alias no capture");

    // R5 writable RAM mode (bits 5:4 = 10), bank 1
    wr(13'h0280, 8'h21);
    for (int o = 0; o < 2048; o += 13) wr(13'h1800 + 13'(o), 8'(o * 7 + 3));
    for (int o = 0; o < 2048; o += 13) rd(13'h1800 + 13'(o), ram_m[o], "R4 R5 ram readback");
    rd(13'h1400, rom_exp(1, 12'h400), "R3 lower rom with overlay");

    // R5 read-only RAM mode (00): writes ignored
    wr(13'h0280, 8'h02);
    for (int o = 0; o < 2048; o += 91) wr(13'h1800 + 13'(o), 8'hA5);
    for (int o = 0; o < 2048; o += 91) rd(13'h1800 + 13'(o), ram_m[o], "R5 ram write-protected");

    // R5 R9 ROM overlay mode (11): write to upper half hits neither
    wr(13'h0280, 8'h32);
    wr(13'h1900, 8'h5A);
    rd(13'h1900, rom_exp(2, 12'h900), "R9 upper rom unchanged");
    wr(13'h1100, 8'h5A);
    rd(13'h1100, rom_exp(2, 12'h100), "R9 lower rom unchanged");
    wr(13'h0280, 8'h22);
    rd(13'h1900, ram_m[12'h100], "R5 ram untouched by rom-mode write");
    wr(13'h1080, 8'hC3);
    rd(13'h1080, rom_exp(2, 12'h080), "R9 lower rom in ram mode");

    // R7 R8 column counter
    wr(13'h0280, 8'h30);
    cmp(col_o, col_m, "R7 clear");
    for (int i = 0; i < 12; i++) begin
      wr(13'h0280, 8'h50);
      cmp(col_o, col_m, "R8 advance/wrap");
    end
    wr(13'h0280, 8'h10);
    cmp(col_o, col_m, "R8 no bit6 holds");
    for (int i = 0; i < 5; i++) wr(13'h0280, 8'h40 | 8'(i % 4) | 8'h10);
    wr(13'h0280, 8'h61);
    cmp(col_o, 1, "R8 clear then advance");
    rd(13'h1800, ram_m[0], "R8 same-write mapping (ram writable)");
    rd(13'h1000, rom_exp(1, 0), "R2 same-write bank");
    wr(13'h0280, 8'h73);
    cmp(col_o, 1, "R8 both bits from 1");
    rd(13'h1810, rom_exp(3, 12'h810), "R4 same-write rom overlay");

    // R6 reset keeps RAM
    @(negedge clk_i);
    rst_ni = 1'b0;
    @(negedge clk_i);
    rst_ni = 1'b1;
    port_m = 8'hFF; col_m = 0;
    @(negedge clk_i);
    cmp(col_o, 0, "R6 col after reset");
    rd(13'h1800 + 13'd26, rom_exp(3, 12'h81A), "R6 port all ones");
    wr(13'h0280, 8'h00);
    for (int o = 0; o < 2048; o += 13)
      if (ram_v[o]) rd(13'h1800 + 13'(o), model_rd(13'h1800 + 13'(o)), "R6 ram kept");

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule